// File: doc/BRIEF.md
# Serial Audio Host Frame Timing Generator

This block produces the bit clock and the word-select / frame-sync waveform of a serial audio port that acts as clock host. A programmable divider derives the bit clock from the block clock. A bit counter and a slot counter walk through each frame. From their position the block derives the word-select level for two-channel formats (standard and left-justified) and for multi-slot TDM formats (delayed or undelayed). The TDM frame sync can last one slot, half the frame's slots, or a single bit.

Alongside the waveform, the block gives the data path its timing. A level marks the MSB bit period of each slot. A one-clock strobe fires when a new slot's MSB begins. The current slot and bit indices are also output. All outputs change on the falling edge of the bit clock. Configuration is captured only while the block is disabled, and a new frame starts cleanly each time enable rises.

Top module: `i2s_host_timing`

## Requirements
- R1: With divider value D > 0, the bit clock has a period of 2·D block-clock cycles. It is low for the first D cycles after the enable edge and then alternates every D cycles.
- R2: With D = 0 (bypass), the bit clock is the inverted block clock while running. The frame advances by one bit on every block-clock cycle.
- R3: Slot length follows the data-length code. Code 0 gives 32 bits. Codes 1, 2 and 3 give 32 bits, or 24 bits when the short-slot select is 1. Codes 4 and 5 give 16 bits, and codes 6 and 7 give 8 bits. The bit index counts from 0 (MSB) to length−1.
- R4: Format code 0 (standard) has two slots. Word select is low for slot 0 (left) and high for slot 1. It changes one bit period before each slot's MSB. The first bit period after enable is a lead bit that sits at the last position of the frame.
- R5: Format code 1 (left-justified) has two slots. Word select is high for slot 0 and low for slot 1. It changes on the same bit as the MSB, and the first bit period after enable is slot 0's MSB.
- R6: Format codes 2 (delayed TDM) and 3 (undelayed TDM) give a frame of channel-field + 1 slots. Frame sync is high for slot 0 (sync style 0 or 3). In code 2 it leads the MSB by one bit and starts with a lead bit, as in R4. In code 3 it is aligned with the MSB.
- R7: In the TDM formats, sync style 1 holds frame sync high for the first max(N/2, 1) slots, where N is the slot count and N/2 is rounded down. Sync style 2 holds it high for exactly one bit period.
- R8: The MSB output is high during bit 0 of every slot. The slot strobe is high for exactly the one block-clock cycle that follows the falling bit-clock edge that starts a slot's bit 0. The slot index output gives the current slot.
- R9: While enable is low, the bit clock, word select, MSB output and slot strobe are low, and the indices are zero.
- R10: Changes to the configuration inputs while enabled have no effect until enable falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block (source) clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; configuration is captured while low |
| fmt_i | input | 2 | Framing format code (0 standard, 1 left-justified, 2 delayed TDM, 3 undelayed TDM) |
| slot24_i | input | 1 | Short 24-bit slot for 18/20/24-bit data |
| sync_i | input | 2 | TDM frame-sync style (0 slot, 1 half frame, 2 one bit) |
| nch_i | input | 3 | TDM slot count minus one |
| dlen_i | input | 3 | Data-length code |
| div_i | input | 6 | Bit-clock divider value, 0 = bypass |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select / frame sync |
| msb_o | output | 1 | High during the MSB bit of each slot |
| slot_stb_o | output | 1 | One-cycle strobe at the start of each slot |
| slot_idx_o | output | 3 | Current slot index |
| bit_idx_o | output | 5 | Current bit index within the slot |

## Verification
The assertions assume a synchronous reset at start-up. They also assume the configuration inputs are meaningful when captured, and that the bounds checks hold only while the captured values stay fixed through a run. The stimulus therefore changes configuration only while enable is low, except in deliberate tests that scramble the inputs mid-run to show they are ignored. Divider values are kept small so that several whole frames fit into each run.

// File: rtl/i2s_tmg_pkg.sv
package i2s_tmg_pkg;

  typedef enum logic [1:0] {
    FMT_STD   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_TDM   = 2'd2,
    FMT_TDMLJ = 2'd3
  } fmt_e;

  // slot length in bits for a data-length code
  function automatic logic [5:0] slot_len(input logic [2:0] code, input logic short24);
    case (code)
      3'd0:             slot_len = 6'd32;
      3'd1, 3'd2, 3'd3: slot_len = short24 ? 6'd24 : 6'd32;
      3'd4, 3'd5:       slot_len = 6'd16;
      default:          slot_len = 6'd8;
    endcase
  endfunction

endpackage

// File: rtl/i2s_tmg_clkdiv.sv
module i2s_tmg_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DIV_W-1:0] div,
  output logic             bclk_q,
  output logic             adv
);

  logic [DIV_W-1:0] cnt;
  logic             bypass;
  logic             wrap;

  assign bypass = (div == '0);
  assign wrap   = (cnt == div - 1'b1);
  assign adv    = go && (bypass || (wrap && bclk_q));

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      cnt    <= '0;
      bclk_q <= 1'b0;
    end else if (!bypass) begin
      if (wrap) begin
        cnt    <= '0;
        bclk_q <= ~bclk_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (go && !bypass) |-> (cnt < div));

  a_r2_bypass_flat: assert property (@(posedge clk) disable iff (rst)
    bypass |-> !bclk_q);

endmodule

// File: rtl/i2s_tmg_framer.sv
module i2s_tmg_framer import i2s_tmg_pkg::*; #(
  parameter int NCH_W = 3,
  parameter int BIT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             start,
  input  logic             adv,
  input  logic [1:0]       fmt,
  input  logic             slot24,
  input  logic [1:0]       sync,
  input  logic [NCH_W-1:0] nch,
  input  logic [2:0]       dlen,
  output logic             ws_q,
  output logic             msb_q,
  output logic             stb_q,
  output logic [NCH_W-1:0] slot_q,
  output logic [BIT_W-1:0] bit_q
);

  localparam int POS_W = BIT_W + NCH_W;

  fmt_e             fmt_t;
  logic [5:0]       len;
  logic [NCH_W:0]   nslots;
  logic [NCH_W:0]   half;
  logic [BIT_W-1:0] last_bit;
  logic [NCH_W-1:0] last_slot;
  logic             dly;
  logic [BIT_W-1:0] p_bit, r_bit;
  logic [NCH_W-1:0] p_slot, r_slot;
  logic             ws_d;

  function automatic logic [POS_W-1:0] step(input logic [BIT_W-1:0] b, input logic [NCH_W-1:0] s,
                                            input logic [BIT_W-1:0] lb, input logic [NCH_W-1:0] ls);
    logic [BIT_W-1:0] nb;
    logic [NCH_W-1:0] ns;
    if (b == lb) begin
      nb = '0;
      ns = (s == ls) ? '0 : s + 1'b1;
    end else begin
      nb = b + 1'b1;
      ns = s;
    end
    return {nb, ns};
  endfunction

  assign fmt_t     = fmt_e'(fmt);
  assign len       = slot_len(dlen, slot24);
  assign nslots    = fmt[1] ? ({1'b0, nch} + 1'b1) : (NCH_W+1)'(2);
  assign half      = ((nslots >> 1) == '0) ? (NCH_W+1)'(1) : (nslots >> 1);
  assign last_bit  = BIT_W'(len - 6'd1);
  assign last_slot = NCH_W'(nslots - 1'b1);
  assign dly       = !fmt[0];

  always_comb begin
    if (start) begin
      p_bit  = dly ? last_bit  : '0;
      p_slot = dly ? last_slot : '0;
    end else begin
      {p_bit, p_slot} = step(bit_q, slot_q, last_bit, last_slot);
    end
    if (dly) {r_bit, r_slot} = step(p_bit, p_slot, last_bit, last_slot);
    else     {r_bit, r_slot} = {p_bit, p_slot};
    case (fmt_t)
      FMT_STD:  ws_d = (r_slot == NCH_W'(1));
      FMT_LEFT: ws_d = (r_slot == '0);
      default: begin
        case (sync)
          2'd1:    ws_d = ({1'b0, r_slot} < half);
          2'd2:    ws_d = (r_slot == '0) && (r_bit == '0);
          default: ws_d = (r_slot == '0);
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    stb_q <= 1'b0;
    if (rst) begin
      ws_q   <= 1'b0;
      msb_q  <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
    end else if (start || adv) begin
      ws_q   <= ws_d;
      msb_q  <= (p_bit == '0);
      stb_q  <= (p_bit == '0);
      slot_q <= p_slot;
      bit_q  <= p_bit;
    end else if (!go) begin
      ws_q   <= 1'b0;
      msb_q  <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
    end
  end

  a_r8_stb_is_msb: assert property (@(posedge clk) disable iff (rst)
    stb_q |-> msb_q);

  a_r3_bit_bound: assert property (@(posedge clk) disable iff (rst)
    go |-> ({1'b0, bit_q} < len));

  a_r6_slot_bound: assert property (@(posedge clk) disable iff (rst)
    go |-> ({1'b0, slot_q} < nslots));

endmodule

// File: rtl/i2s_host_timing.sv
module i2s_host_timing #(
  parameter int DIV_W = 6,
  parameter int NCH_W = 3,
  parameter int BIT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       fmt_i,
  input  logic             slot24_i,
  input  logic [1:0]       sync_i,
  input  logic [NCH_W-1:0] nch_i,
  input  logic [2:0]       dlen_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             msb_o,
  output logic             slot_stb_o,
  output logic [NCH_W-1:0] slot_idx_o,
  output logic [BIT_W-1:0] bit_idx_o
);

  logic [1:0]       fmt_q;
  logic             slot24_q;
  logic [1:0]       sync_q;
  logic [NCH_W-1:0] nch_q;
  logic [2:0]       dlen_q;
  logic [DIV_W-1:0] div_q;
  logic             run_q;
  logic             go, start, adv, bclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q    <= '0;
      slot24_q <= 1'b0;
      sync_q   <= '0;
      nch_q    <= '0;
      dlen_q   <= '0;
      div_q    <= '0;
      run_q    <= 1'b0;
    end else begin
      run_q <= en;
      if (!en) begin
        fmt_q    <= fmt_i;
        slot24_q <= slot24_i;
        sync_q   <= sync_i;
        nch_q    <= nch_i;
        dlen_q   <= dlen_i;
        div_q    <= div_i;
      end
    end
  end

  assign go    = en && run_q;
  assign start = en && !run_q;

  i2s_tmg_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .go(go), .div(div_q), .bclk_q(bclk_q), .adv(adv)
  );

  i2s_tmg_framer #(.NCH_W(NCH_W), .BIT_W(BIT_W)) u_frm (
    .clk(clk), .rst(rst), .go(go), .start(start), .adv(adv),
    .fmt(fmt_q), .slot24(slot24_q), .sync(sync_q), .nch(nch_q), .dlen(dlen_q),
    .ws_q(ws_o), .msb_q(msb_o), .stb_q(slot_stb_o), .slot_q(slot_idx_o), .bit_q(bit_idx_o)
  );

  // bypass: outputs move on the rising source edge, which is the falling bit-clock edge
  assign bclk_o = (div_q == '0) ? (run_q & ~clk) : bclk_q;

  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!ws_o && !slot_stb_o && !msb_o && !bclk_q));

  a_r8_stb_on_fall: assert property (@(posedge clk) disable iff (rst)
    (slot_stb_o && div_q != '0) |-> !bclk_q);

  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (en && run_q) |=> $stable({fmt_q, slot24_q, sync_q, nch_q, dlen_q, div_q}));

endmodule

// File: tb/sim_i2s_host_timing.sv
`timescale 1ns/1ps
module sim_i2s_host_timing;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] fmt_i = '0;
  logic       slot24_i = 1'b0;
  logic [1:0] sync_i = '0;
  logic [2:0] nch_i = '0;
  logic [2:0] dlen_i = '0;
  logic [5:0] div_i = 6'd1;
  logic       bclk_o, ws_o, msb_o, slot_stb_o;
  logic [2:0] slot_idx_o;
  logic [4:0] bit_idx_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2s_host_timing u0 (
    .clk(clk), .rst(rst), .en(en), .fmt_i(fmt_i), .slot24_i(slot24_i), .sync_i(sync_i),
    .nch_i(nch_i), .dlen_i(dlen_i), .div_i(div_i), .bclk_o(bclk_o), .ws_o(ws_o),
    .msb_o(msb_o), .slot_stb_o(slot_stb_o), .slot_idx_o(slot_idx_o), .bit_idx_o(bit_idx_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int ref_len(input int code, input int s24);
    if (code == 0) return 32;
    if (code <= 3) return s24 ? 24 : 32;
    if (code <= 5) return 16;
    return 8;
  endfunction

  function automatic int ref_ws(input int fmt, input int sync, input int ns, input int len, input int pos);
    int slot, bitn, half;
    slot = pos / len;
    bitn = pos % len;
    half = (ns / 2 == 0) ? 1 : ns / 2;
    if (fmt == 0) return (slot == 1) ? 1 : 0;
    if (fmt == 1) return (slot == 0) ? 1 : 0;
    if (sync == 1) return (slot < half) ? 1 : 0;
    if (sync == 2) return (slot == 0 && bitn == 0) ? 1 : 0;
    return (slot == 0) ? 1 : 0;
  endfunction

  task automatic idle_check(input string tag);
    check("R9", {tag, " bclk"}, int'(bclk_o), 0);
    check("R9", {tag, " ws"}, int'(ws_o), 0);
    check("R9", {tag, " msb"}, int'(msb_o), 0);
    check("R9", {tag, " stb"}, int'(slot_stb_o), 0);
    check("R9", {tag, " idx"}, int'({slot_idx_o, bit_idx_o}), 0);
  endtask

  // run one configuration for a number of frames and compare every cycle
  task automatic run_cfg(input int fmt, input int s24, input int sync, input int nch,
                         input int dlen, input int div, input int frames, input bit scramble);
    int len, ns, fbits, dly, cyc, hp, pos, rpos, bitn, slot;
    string wreq;
    @(negedge clk);
    fmt_i = fmt[1:0]; slot24_i = s24[0]; sync_i = sync[1:0];
    nch_i = nch[2:0]; dlen_i = dlen[2:0]; div_i = div[5:0];
    @(negedge clk);
    en = 1'b1;
    len   = ref_len(dlen, s24);
    ns    = (fmt >= 2) ? nch + 1 : 2;
    fbits = ns * len;
    dly   = (fmt == 0 || fmt == 2) ? 1 : 0;
    hp    = (div == 0) ? 1 : div;
    cyc   = frames * fbits * 2 * hp;
    wreq  = (fmt == 0) ? "R4" : (fmt == 1) ? "R5" : (sync == 1 || sync == 2) ? "R7" : "R6";
    for (int k = 0; k < cyc; k++) begin
      int b;
      @(negedge clk);
      if (scramble && k == cyc / 2) begin
        fmt_i = ~fmt_i; slot24_i = ~slot24_i; sync_i = sync_i + 2'd1;
        nch_i = ~nch_i; dlen_i = dlen_i + 3'd3; div_i = div_i + 6'd2;
      end
      if (scramble && k > cyc / 2) wreq = "R10";
      b    = (div == 0) ? k : k / (2 * div);
      pos  = (dly ? fbits - 1 + b : b) % fbits;
      rpos = dly ? (pos + 1) % fbits : pos;
      bitn = pos % len;
      slot = pos / len;
      if (div == 0) check(scramble ? "R10" : "R2", "bclk", int'(bclk_o), 1);
      else          check(scramble ? "R10" : "R1", "bclk", int'(bclk_o), ((k / div) % 2));
      check(wreq, "ws", int'(ws_o), ref_ws(fmt, sync, ns, len, rpos));
      check(scramble ? "R10" : "R3", "bit_idx", int'(bit_idx_o), bitn);
      check("R8", "slot_idx", int'(slot_idx_o), slot);
      check("R8", "msb", int'(msb_o), (bitn == 0) ? 1 : 0);
      check("R8", "stb", int'(slot_stb_o),
            (bitn == 0 && (div == 0 || k % (2 * div) == 0)) ? 1 : 0);
    end
    en = 1'b0;
    @(negedge clk);
    idle_check("after run");
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    idle_check("in reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    idle_check("after reset");

    run_cfg(0, 0, 0, 0, 4, 1, 2, 1'b0);  // R4 standard, 16-bit, fastest divider
    run_cfg(1, 1, 0, 0, 1, 2, 2, 1'b0);  // R5 left-justified, 24-bit slot R3
    run_cfg(1, 0, 0, 0, 2, 1, 1, 1'b0);  // R3 20-bit data in 32-bit slot
    run_cfg(2, 0, 0, 3, 6, 2, 2, 1'b0);  // R6 delayed TDM, 4 slots
    run_cfg(3, 0, 0, 7, 7, 1, 2, 1'b0);  // R6 undelayed TDM, 8 slots
    run_cfg(2, 0, 1, 4, 6, 1, 2, 1'b0);  // R7 half-frame sync, odd slot count
    run_cfg(3, 0, 1, 0, 6, 1, 2, 1'b0);  // R7 half-frame sync with one slot
    run_cfg(2, 0, 2, 2, 4, 3, 2, 1'b0);  // R7 one-bit sync
    run_cfg(0, 0, 0, 0, 6, 0, 3, 1'b0);  // R2 bypass divider
    run_cfg(3, 1, 3, 1, 3, 0, 2, 1'b0);  // R2 bypass with TDM, style 3
    run_cfg(0, 1, 0, 0, 3, 2, 2, 1'b1);  // R10 scramble inputs mid-run
    run_cfg(2, 0, 2, 3, 4, 1, 2, 1'b1);  // R10 scramble during TDM

    for (int i = 0; i < 14; i++) begin
      int f, s24, sy, nc, dl, dv;
      f   = int'($urandom_range(3, 0));
      s24 = int'($urandom_range(1, 0));
      sy  = int'($urandom_range(3, 0));
      nc  = int'($urandom_range(7, 0));
      dl  = int'($urandom_range(7, 0));
      dv  = int'($urandom_range(3, 0));
      run_cfg(f, s24, sy, nc, dl, dv, 1, 1'b0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule